// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register side of a general-purpose I/O port. A simple 32-bit read/write bus reaches per-pin direction, output-latch and glitch-filter-bypass state, plus a read-only view of the synchronized pin inputs. The pins are grouped in banks of 32. Each register kind has a base offset, and bank `b` of that kind sits at the base plus `4*b`. Within that word, pin `n` uses bit `n % 32`.

The output latch can never be written directly. Software raises bits through a set window and lowers them through a clear window, so two agents can each change their own pins without a read-modify-write race. The direction bits drive the pad output enables. The filter-bypass bits and the synchronized pin levels are exported to a separate interrupt-detection block. That block owns the remaining offsets of the map, which read as zero here.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every direction bit, output-latch bit and filter-bypass bit is 0, so `pad_oe`, `pad_out` and `filt_bypass` are all zero and their readbacks return 0.
- R2: A register kind with base offset B serves pin n in the word at byte address B + 4*(n/32), bit n%32. The base offsets are: level 0x004, direction 0x01C, set 0x034, clear 0x04C, filter bypass 0x094.
- R3: The level word returns each pin input after a two-flop synchronizer. A change on `pad_in` reaches `pin_level` on the second rising clock edge after it. Writes to the level word have no effect.
- R4: A write to the set word sets the output-latch bit for every 1 in the write data and leaves the bits under the 0s unchanged. The latch is visible on `pad_out` after that clock edge.
- R5: A write to the clear word clears the output-latch bit for every 1 in the write data and leaves the bits under the 0s unchanged.
- R6: The direction word is read/write. A 1 drives the pin's `pad_oe` high (output) and a 0 makes the pin an input.
- R7: The filter-bypass word is read/write, and each bit appears on `filt_bypass` for its pin. A 1 means the filter is bypassed.
- R8: Reads of the set and clear words return 0.
- R9: Bits for pin indices at or above `NUM_PINS` read as 0 and ignore writes.
- R10: Read data is registered. `bus_rdata` carries the addressed word in the cycle after `bus_rd` and is 0 in any cycle that does not follow a read. Addresses that are unaligned or that do not fall in one of the five windows read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | NUM_PINS | Raw pin inputs |
| pad_out | output | NUM_PINS | Output latch |
| pad_oe | output | NUM_PINS | Output enables (direction bits) |
| pin_level | output | NUM_PINS | Synchronized pin levels for the interrupt logic |
| filt_bypass | output | NUM_PINS | Per-pin glitch-filter bypass for the interrupt logic |

## Verification
The bench builds the block with `NUM_PINS = 40`. This gives one full bank and a second bank with only eight live lanes. That single setting reaches the 4-byte bank stride in every window, the zeroing and write-ignoring of lanes 40 to 63, and a decode for two banks. With two banks, the windows of neighbouring register kinds lie close enough together that a probe at the next unused word (for example 0x09C) checks the window ends.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned LANES = 32;

  localparam logic [31:0] OFS_LEVEL  = 32'h004;
  localparam logic [31:0] OFS_DIR    = 32'h01C;
  localparam logic [31:0] OFS_SET    = 32'h034;
  localparam logic [31:0] OFS_CLR    = 32'h04C;
  localparam logic [31:0] OFS_BYPASS = 32'h094;

  // windows of neighbouring kinds are 0x18 apart: at most 6 banks fit
  localparam int unsigned MAX_BANKS = 6;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_LEVEL,
    KIND_DIR,
    KIND_SET,
    KIND_CLR,
    KIND_BYPASS
  } reg_kind_e;

  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input int unsigned nbanks);
    return (addr >= base) && (addr < base + 32'(4 * nbanks)) && (addr[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BANK_W-1:0] bank
);
  logic [31:0] addr_ext;
  logic [31:0] delta;

  assign addr_ext = 32'(addr);

  always_comb begin
    kind  = KIND_NONE;
    delta = '0;
    if (in_window(addr_ext, OFS_LEVEL, NUM_BANKS)) begin
      kind  = KIND_LEVEL;
      delta = addr_ext - OFS_LEVEL;
    end else if (in_window(addr_ext, OFS_DIR, NUM_BANKS)) begin
      kind  = KIND_DIR;
      delta = addr_ext - OFS_DIR;
    end else if (in_window(addr_ext, OFS_SET, NUM_BANKS)) begin
      kind  = KIND_SET;
      delta = addr_ext - OFS_SET;
    end else if (in_window(addr_ext, OFS_CLR, NUM_BANKS)) begin
      kind  = KIND_CLR;
      delta = addr_ext - OFS_CLR;
    end else if (in_window(addr_ext, OFS_BYPASS, NUM_BANKS)) begin
      kind  = KIND_BYPASS;
      delta = addr_ext - OFS_BYPASS;
    end
  end

  assign bank = BANK_W'(delta >> 2);
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice #(
  parameter int unsigned VALID_LANES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_dir,
  input  logic                   we_set,
  input  logic                   we_clr,
  input  logic                   we_byp,
  input  logic [VALID_LANES-1:0] wdata,
  input  logic [VALID_LANES-1:0] pin_raw,
  output logic [VALID_LANES-1:0] out_q,
  output logic [VALID_LANES-1:0] dir_q,
  output logic [VALID_LANES-1:0] byp_q,
  output logic [VALID_LANES-1:0] level
);
  logic [VALID_LANES-1:0] out_d;
  logic [VALID_LANES-1:0] dir_d;
  logic [VALID_LANES-1:0] byp_d;
  logic                   out_en;
  logic                   dir_en;
  logic                   byp_en;

  // next state
  always_comb begin
    out_en = we_set | we_clr;
    dir_en = we_dir;
    byp_en = we_byp;
    dir_d  = wdata;
    byp_d  = wdata;
    if (we_set) begin
      out_d = out_q | wdata;
    end else begin
      out_d = out_q & ~wdata;
    end
  end

  // state registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= '0;
    end else if (byp_en) begin
      byp_q <= byp_d;
    end
  end

  gpio_sync2 #(.WIDTH(VALID_LANES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_raw),
    .dout  (level)
  );
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 1
) (
  input  reg_kind_e         kind,
  input  logic [BANK_W-1:0] bank,
  input  logic [31:0]       lvl_w [NUM_BANKS],
  input  logic [31:0]       dir_w [NUM_BANKS],
  input  logic [31:0]       byp_w [NUM_BANKS],
  output logic [31:0]       word
);
  always_comb begin
    word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(bank) == 32'(b)) begin
        case (kind)
          KIND_LEVEL:  word = lvl_w[b];
          KIND_DIR:    word = dir_w[b];
          KIND_BYPASS: word = byp_w[b];
          default:     word = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] filt_bypass
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + LANES - 1) / LANES;
  localparam int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic        rst_sync_n;
  reg_kind_e   kind;
  logic [BANK_W-1:0] bank;
  logic [31:0] lvl_w [NUM_BANKS];
  logic [31:0] dir_w [NUM_BANKS];
  logic [31:0] byp_w [NUM_BANKS];
  logic [31:0] rd_word;
  logic [31:0] rdata_d;
  logic [31:0] rdata_q;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_addr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .bank (bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LO = b * LANES;
    localparam int unsigned VL = ((NUM_PINS - LO) < LANES) ? (NUM_PINS - LO) : LANES;

    logic          sel;
    logic [VL-1:0] out_b;
    logic [VL-1:0] dir_b;
    logic [VL-1:0] byp_b;
    logic [VL-1:0] lvl_b;

    assign sel = bus_wr && (32'(bank) == 32'(b));

    gpio_bank_slice #(.VALID_LANES(VL)) u_slice (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .we_dir  (sel && (kind == KIND_DIR)),
      .we_set  (sel && (kind == KIND_SET)),
      .we_clr  (sel && (kind == KIND_CLR)),
      .we_byp  (sel && (kind == KIND_BYPASS)),
      .wdata   (bus_wdata[VL-1:0]),
      .pin_raw (pad_in[LO +: VL]),
      .out_q   (out_b),
      .dir_q   (dir_b),
      .byp_q   (byp_b),
      .level   (lvl_b)
    );

    assign pad_out[LO +: VL]     = out_b;
    assign pad_oe[LO +: VL]      = dir_b;
    assign filt_bypass[LO +: VL] = byp_b;
    assign pin_level[LO +: VL]   = lvl_b;
    assign lvl_w[b] = 32'(lvl_b);
    assign dir_w[b] = 32'(dir_b);
    assign byp_w[b] = 32'(byp_b);
  end

  gpio_read_mux #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_rmux (
    .kind  (kind),
    .bank  (bank),
    .lvl_w (lvl_w),
    .dir_w (dir_w),
    .byp_w (byp_w),
    .word  (rd_word)
  );

  always_comb begin
    rdata_d = bus_rd ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned ADDR_W   = 10
) (
  input logic                clk,
  input logic                rst_ni,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pin_level,
  input logic [NUM_PINS-1:0] filt_bypass
);
  localparam int unsigned NB = (NUM_PINS + LANES - 1) / LANES;

  logic hit_set;
  logic hit_clr;
  logic [1:0] since_rst;

  assign hit_set = in_window(32'(bus_addr), OFS_SET, NB);
  assign hit_clr = in_window(32'(bus_addr), OFS_CLR, NB);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd2) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  // R3: two-flop synchronizer latency
  a_r3_level_two_flops: assert property (@(posedge clk) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (pin_level == $past(pad_in, 2)));

  // R4: a set write never lowers a latch bit
  a_r4_set_never_lowers: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && hit_set) |=> ((pad_out & $past(pad_out)) == $past(pad_out)));

  // R5: a clear write never raises a latch bit
  a_r5_clear_never_raises: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && hit_clr) |=> ((pad_out | $past(pad_out)) == $past(pad_out)));

  // R4, R5: the latch moves only on a write
  a_r4_latch_holds_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_wr |=> $stable(pad_out));

  // R6: the direction bits move only on a write
  a_r6_dir_holds_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_wr |=> $stable(pad_oe));

  // R7: the bypass bits move only on a write
  a_r7_bypass_holds_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_wr |=> $stable(filt_bypass));

  // R8: set and clear words read as zero
  a_r8_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && (hit_set || hit_clr)) |=> (bus_rdata == 32'd0));

  // R10: no read, no data
  a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_rd |=> (bus_rdata == 32'd0));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pin_level   (pin_level),
  .filt_bypass (filt_bypass)
);

// File: tb/gpio_bank_regs_bench.sv
`timescale 1ns/1ps
module gpio_bank_regs_bench;
  localparam int NP = 40;
  localparam int AW = 10;

  logic          clk;
  logic          rst_n;
  logic          bus_wr;
  logic          bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pin_level;
  logic [NP-1:0] filt_bypass;

  int n_checks;
  int n_fails;
  logic [NP-1:0] exp_out;
  logic [NP-1:0] exp_oe;
  logic [NP-1:0] exp_byp;

  gpio_bank_regs #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_bank_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pin_level   (pin_level),
    .filt_bypass (filt_bypass)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // lanes of bank bk that exist for NP pins
  function automatic logic [NP-1:0] spread(input int bk, input logic [31:0] d);
    logic [NP-1:0] v = '0;
    for (int i = 0; i < 32; i++) begin
      if (bk * 32 + i < NP) v[bk * 32 + i] = d[i];
    end
    return v;
  endfunction

  task automatic check_pins(input string req);
    check({req, " pad_out"}, 64'(pad_out), 64'(exp_out));
    check({req, " pad_oe"}, 64'(pad_oe), 64'(exp_oe));
    check({req, " filt_bypass"}, 64'(filt_bypass), 64'(exp_byp));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check_pins("R1 reset");
    bus_read(10'h01C, d); check("R1 dir bank0", 64'(d), 64'h0);
    bus_read(10'h020, d); check("R1 dir bank1", 64'(d), 64'h0);
    bus_read(10'h094, d); check("R1 bypass bank0", 64'(d), 64'h0);
  endtask

  task automatic t_set_clear;
    bus_write(10'h034, 32'hA5A5_0001); exp_out |= spread(0, 32'hA5A5_0001);
    check("R4 set bank0", 64'(pad_out), 64'(exp_out));
    bus_write(10'h034, 32'h0000_0F00); exp_out |= spread(0, 32'h0000_0F00);
    check("R4 set zeros keep", 64'(pad_out), 64'(exp_out));
    bus_write(10'h04C, 32'h8000_0001); exp_out &= ~spread(0, 32'h8000_0001);
    check("R5 clear bank0", 64'(pad_out), 64'(exp_out));
    bus_write(10'h038, 32'hFFFF_FFFF); exp_out |= spread(1, 32'hFFFF_FFFF);
    check("R2 R9 set bank1", 64'(pad_out), 64'(exp_out));
    bus_write(10'h050, 32'h0000_000F); exp_out &= ~spread(1, 32'h0000_000F);
    check("R5 clear bank1", 64'(pad_out), 64'(exp_out));
    check_pins("R4 R5 pins after latch writes");
  endtask

  task automatic t_strobe_reads;
    logic [31:0] d;
    bus_read(10'h034, d); check("R8 set bank0 read", 64'(d), 64'h0);
    bus_read(10'h038, d); check("R8 set bank1 read", 64'(d), 64'h0);
    bus_read(10'h04C, d); check("R8 clear bank0 read", 64'(d), 64'h0);
    bus_read(10'h050, d); check("R8 clear bank1 read", 64'(d), 64'h0);
  endtask

  task automatic t_direction;
    logic [31:0] d;
    bus_write(10'h01C, 32'h1234_5678); exp_oe = (exp_oe & ~spread(0, '1)) | spread(0, 32'h1234_5678);
    bus_write(10'h020, 32'hFFFF_FFFF); exp_oe = (exp_oe & ~spread(1, '1)) | spread(1, 32'hFFFF_FFFF);
    bus_read(10'h01C, d); check("R6 dir bank0 readback", 64'(d), 64'h1234_5678);
    bus_read(10'h020, d); check("R9 dir bank1 upper lanes zero", 64'(d), 64'h0000_00FF);
    check("R6 pad_oe", 64'(pad_oe), 64'(exp_oe));
  endtask

  task automatic t_bypass;
    logic [31:0] d;
    bus_write(10'h094, 32'h0F0F_0F0F); exp_byp = (exp_byp & ~spread(0, '1)) | spread(0, 32'h0F0F_0F0F);
    bus_write(10'h098, 32'hFFFF_00AA); exp_byp = (exp_byp & ~spread(1, '1)) | spread(1, 32'hFFFF_00AA);
    bus_read(10'h094, d); check("R7 bypass bank0 readback", 64'(d), 64'h0F0F_0F0F);
    bus_read(10'h098, d); check("R7 R9 bypass bank1 readback", 64'(d), 64'h0000_00AA);
    check("R7 filt_bypass", 64'(filt_bypass), 64'(exp_byp));
  endtask

  task automatic t_level;
    logic [31:0] d;
    logic [NP-1:0] pat = 40'hA5_1234_5678;
    @(negedge clk);
    pad_in = pat;
    @(negedge clk);
    check("R3 level after one edge unchanged", 64'(pin_level), 64'h0);
    @(negedge clk);
    check("R3 level after two edges", 64'(pin_level), 64'(pat));
    bus_read(10'h004, d); check("R3 level bank0 read", 64'(d), 64'h1234_5678);
    bus_read(10'h008, d); check("R2 level bank1 read", 64'(d), 64'h0000_00A5);
    bus_write(10'h004, 32'hFFFF_FFFF);
    bus_write(10'h008, 32'h0000_0000);
    bus_read(10'h004, d); check("R3 level write ignored", 64'(d), 64'h1234_5678);
    bus_read(10'h008, d); check("R3 level bank1 write ignored", 64'(d), 64'h0000_00A5);
    check_pins("R3 level write no side effect");
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_write(10'h000, 32'hFFFF_FFFF);
    bus_write(10'h064, 32'hFFFF_FFFF);
    bus_write(10'h09C, 32'hFFFF_FFFF);
    bus_write(10'h0AC, 32'hFFFF_FFFF);
    bus_write(10'h300, 32'hFFFF_FFFF);
    bus_write(10'h01E, 32'h0000_0000);
    bus_write(10'h036, 32'hFFFF_FFFF);
    check_pins("R10 unmapped writes ignored");
    bus_read(10'h000, d); check("R10 offset 0x000 reads zero", 64'(d), 64'h0);
    bus_read(10'h09C, d); check("R10 past bypass window reads zero", 64'(d), 64'h0);
    bus_read(10'h300, d); check("R10 offset 0x300 reads zero", 64'(d), 64'h0);
    bus_read(10'h01D, d); check("R10 unaligned reads zero", 64'(d), 64'h0);
    bus_read(10'h01C, d);
    check("R10 dir kept after stray writes", 64'(d), 64'h1234_5678);
    @(negedge clk);
    check("R10 rdata zero without read", 64'(bus_rdata), 64'h0);
  endtask

  logic finished;

  initial begin
    finished = 1'b0;
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fails = 0;
    exp_out = '0; exp_oe = '0; exp_byp = '0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_clear();
    t_strobe_reads();
    t_direction();
    t_bypass();
    t_level();
    t_unmapped();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule